// File: doc/BRIEF.md
# JTAG Test Access Port Controller with Two User Scan Chains

This block is the test access port of a programmable logic device. A 16-state
controller, stepped by TMS on each rising TCK edge, chooses whether the serial
path from TDI to TDO runs through the instruction register or through one data
register. The instruction register is 10 bits wide. The data registers are a
1-bit bypass stage, a 32-bit identification word, a 32-bit user code word and a
boundary register whose length is a parameter (636 cells by default; 240, 480
and 816 are other usual sizes). In this block the boundary register only
samples a parallel input vector. It does not drive pins.

Two user instructions take the data path away from the internal registers and
send it through chains built in the device's own logic. Each chain gets a select
line and its own capture, shift and update strobes. The chain's serial output
reaches TDO only while its instruction is active. The controller also reports
its state code, so user logic can follow the scan protocol.

States and their codes: TEST_RESET 0, IDLE 1, SEL_DR 2, CAP_DR 3, SHIFT_DR 4,
EXIT1_DR 5, PAUSE_DR 6, EXIT2_DR 7, UPD_DR 8, SEL_IR 9, CAP_IR 10, SHIFT_IR 11,
EXIT1_IR 12, PAUSE_IR 13, EXIT2_IR 14, UPD_IR 15.

Each state moves as follows, written as (next state when TMS=0 / next state when TMS=1):

- TEST_RESET: IDLE / TEST_RESET
- IDLE: IDLE / SEL_DR
- SEL_DR: CAP_DR / SEL_IR
- CAP_DR: SHIFT_DR / EXIT1_DR
- SHIFT_DR: SHIFT_DR / EXIT1_DR
- EXIT1_DR: PAUSE_DR / UPD_DR
- PAUSE_DR: PAUSE_DR / EXIT2_DR
- EXIT2_DR: SHIFT_DR / UPD_DR
- UPD_DR: IDLE / SEL_DR
- SEL_IR: CAP_IR / TEST_RESET
- CAP_IR: SHIFT_IR / EXIT1_IR
- SHIFT_IR: SHIFT_IR / EXIT1_IR
- EXIT1_IR: PAUSE_IR / UPD_IR
- PAUSE_IR: PAUSE_IR / EXIT2_IR
- EXIT2_IR: SHIFT_IR / UPD_IR
- UPD_IR: IDLE / SEL_DR

Top module: `scan_port_ctrl`

## Requirements
- R1: The controller state changes only on the rising edge of `tck` and follows the transition table above. Its code is visible on `tap_state`.
- R2: When `trst_n` is low, the state goes at once to TEST_RESET (code 0), whatever `tck` is doing. Five rising edges in a row with `tms` high also reach TEST_RESET, from any state.
- R3: The instruction register is 10 bits wide. In CAP_IR its shift stage loads 10'b00_0000_0001. Bits shift out LSB first.
- R4: While in TEST_RESET, the active instruction is set to the identification opcode 10'h006. A data scan made straight after reset therefore shifts out the 32-bit identification word, LSB first. The default word is 32'h020A30DD: version 4'h0 in bits 31:28, part number 16'h20A3 in bits 27:12, maker code 11'h06E in bits 11:1, and bit 0 always 1.
- R5: Opcode 10'h007 selects the 32-bit user code register. It captures the parameter value `USERCODE_VAL`.
- R6: Any opcode that the other requirements do not name selects the 1-bit bypass stage. This includes the all-ones opcode 10'h3FF. The bypass stage captures 0, so `tdo` repeats `tdi` one shift later.
- R7: Opcode 10'h005 selects the boundary register, which is `BSR_LEN` bits long. In CAP_DR it captures `bsr_pins_i`, and it shifts out bit 0 first.
- R8: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is 1 only during SHIFT_IR and SHIFT_DR.
- R9: Opcode 10'h00C makes chain 0 active (`usr_sel` = 2'b01) and opcode 10'h00E makes chain 1 active (`usr_sel` = 2'b10). At most one select is high at a time. The active chain's `usr_tdo_i` bit reaches `tdo` only while its instruction is in force.
- R10: `usr_cap[k]` is high for the single cycle spent in CAP_DR, and `usr_upd[k]` for the single cycle spent in UPD_DR. `usr_shf[k]` is high in every SHIFT_DR cycle. All three are gated by `usr_sel[k]`.
- R11: A new instruction takes effect only in UPD_IR. Data scans leave the active instruction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| tap_state | output | 4 | Current controller state code |
| bsr_pins_i | input | BSR_LEN | Parallel values the boundary register captures |
| usr_tdi | output | 1 | Serial data to the user chains |
| usr_tdo_i | input | 2 | Serial outputs of user chains 0 and 1 |
| usr_sel | output | 2 | Chain select, one bit per user instruction |
| usr_cap | output | 2 | Per-chain capture strobe |
| usr_shf | output | 2 | Per-chain shift strobe |
| usr_upd | output | 2 | Per-chain update strobe |

## Verification
The assertions assume that `trst_n` is released away from a rising `tck` edge. They also assume that `tms`, `tdi` and `usr_tdo_i` are steady around the clock edge that samples them, and that the user chains react only to their own strobes. The stimulus keeps to these limits by changing every input one nanosecond after a falling edge. It models each user chain as a register that changes only on rising `tck`, when a strobe is present. It releases reset at the same point in the cycle, so the five-ones counter and the strobe checks always start from a clean TEST_RESET.

// File: rtl/scan_port_pkg.sv
package scan_port_pkg;

    typedef enum logic [3:0] {
        ST_RESET    = 4'd0,
        ST_IDLE     = 4'd1,
        ST_SEL_DR   = 4'd2,
        ST_CAP_DR   = 4'd3,
        ST_SHIFT_DR = 4'd4,
        ST_EXIT1_DR = 4'd5,
        ST_PAUSE_DR = 4'd6,
        ST_EXIT2_DR = 4'd7,
        ST_UPD_DR   = 4'd8,
        ST_SEL_IR   = 4'd9,
        ST_CAP_IR   = 4'd10,
        ST_SHIFT_IR = 4'd11,
        ST_EXIT1_IR = 4'd12,
        ST_PAUSE_IR = 4'd13,
        ST_EXIT2_IR = 4'd14,
        ST_UPD_IR   = 4'd15
    } tap_state_e;

    typedef enum logic [2:0] {
        PATH_BYPASS   = 3'd0,
        PATH_IDCODE   = 3'd1,
        PATH_USERCODE = 3'd2,
        PATH_BOUNDARY = 3'd3,
        PATH_USER0    = 3'd4,
        PATH_USER1    = 3'd5
    } dr_path_e;

    localparam int ID_W   = 32;
    localparam int N_USER = 2;

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
    import scan_port_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       shift_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       shift_ir,
    output logic       upd_ir
);

    tap_state_e nxt;

    always_comb begin
        unique case (state)
            ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   nxt = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   nxt = tms ? ST_SEL_DR   : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

    // State strobes
    always_comb begin
        in_reset = 1'b0;
        cap_dr   = 1'b0;
        shift_dr = 1'b0;
        upd_dr   = 1'b0;
        cap_ir   = 1'b0;
        shift_ir = 1'b0;
        upd_ir   = 1'b0;
        case (state)
            ST_RESET:    in_reset = 1'b1;
            ST_CAP_DR:   cap_dr   = 1'b1;
            ST_SHIFT_DR: shift_dr = 1'b1;
            ST_UPD_DR:   upd_dr   = 1'b1;
            ST_CAP_IR:   cap_ir   = 1'b1;
            ST_SHIFT_IR: shift_ir = 1'b1;
            ST_UPD_IR:   upd_ir   = 1'b1;
            default:     ;
        endcase
    end

    // Run of consecutive high TMS samples, saturating at five
    logic [2:0] ones_run;
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)               ones_run <= 3'd0;
        else if (!tms)             ones_run <= 3'd0;
        else if (ones_run != 3'd5) ones_run <= ones_run + 3'd1;
    end

    p_five_ones_r2: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run == 3'd5) |-> (state == ST_RESET));

    p_capture_once_r10: assert property (@(posedge tck) disable iff (!trst_n)
        cap_dr |=> !cap_dr);

    p_update_once_r10: assert property (@(posedge tck) disable iff (!trst_n)
        upd_dr |=> !upd_dr);

endmodule

// File: rtl/scan_ir.sv
module scan_ir #(
    parameter int              IR_W     = 10,
    parameter logic [IR_W-1:0] RESET_OP = '0
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap_ir,
    input  logic            shift_ir,
    input  logic            upd_ir,
    output logic [IR_W-1:0] ir_q,
    output logic            sr_lsb
);

    localparam logic [IR_W-1:0] CAPTURE_PAT = {{(IR_W-1){1'b0}}, 1'b1};

    logic [IR_W-1:0] ir_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       ir_sr <= '0;
        else if (cap_ir)   ir_sr <= CAPTURE_PAT;
        else if (shift_ir) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)       ir_q <= RESET_OP;
        else if (in_reset) ir_q <= RESET_OP;
        else if (upd_ir)   ir_q <= ir_sr;
    end

    assign sr_lsb = ir_sr[0];

    p_capture_pattern_r3: assert property (@(posedge tck) disable iff (!trst_n)
        cap_ir |=> (ir_sr[1:0] == 2'b01));

    p_reset_loads_id_r4: assert property (@(posedge tck) disable iff (!trst_n)
        in_reset |=> (ir_q == RESET_OP));

    p_ir_held_r11: assert property (@(posedge tck) disable iff (!trst_n)
        (!upd_ir && !in_reset) |=> $stable(ir_q));

endmodule

// File: rtl/scan_decode.sv
module scan_decode
    import scan_port_pkg::*;
#(
    parameter int              IR_W        = 10,
    parameter logic [IR_W-1:0] OP_IDCODE   = 10'h006,
    parameter logic [IR_W-1:0] OP_USERCODE = 10'h007,
    parameter logic [IR_W-1:0] OP_SAMPLE   = 10'h005,
    parameter logic [IR_W-1:0] OP_USER0    = 10'h00C,
    parameter logic [IR_W-1:0] OP_USER1    = 10'h00E
) (
    input  logic [IR_W-1:0] ir_q,
    output dr_path_e        path
);

    always_comb begin
        if      (ir_q == OP_IDCODE)   path = PATH_IDCODE;
        else if (ir_q == OP_USERCODE) path = PATH_USERCODE;
        else if (ir_q == OP_SAMPLE)   path = PATH_BOUNDARY;
        else if (ir_q == OP_USER0)    path = PATH_USER0;
        else if (ir_q == OP_USER1)    path = PATH_USER1;
        else                          path = PATH_BYPASS;
    end

endmodule

// File: rtl/scan_shift_reg.sv
module scan_shift_reg #(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  logic         cap_en,
    input  logic         shift_en,
    input  logic [W-1:0] cap_val,
    output logic         lsb
);

    logic [W-1:0] sr;

    generate
        if (W == 1) begin : g_one
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n)       sr <= '0;
                else if (cap_en)   sr <= cap_val;
                else if (shift_en) sr <= tdi;
            end
        end else begin : g_wide
            always_ff @(posedge tck or negedge trst_n) begin
                if (!trst_n)       sr <= '0;
                else if (cap_en)   sr <= cap_val;
                else if (shift_en) sr <= {tdi, sr[W-1:1]};
            end
        end
    endgenerate

    assign lsb = sr[0];

endmodule

// File: rtl/scan_dr_bank.sv
module scan_dr_bank
    import scan_port_pkg::*;
#(
    parameter int              BSR_LEN      = 636,
    parameter logic [ID_W-1:0] IDCODE_VAL   = 32'h020A30DD,
    parameter logic [ID_W-1:0] USERCODE_VAL = 32'hFFFFFFFF
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tdi,
    input  dr_path_e           path,
    input  logic               cap_dr,
    input  logic               shift_dr,
    input  logic [BSR_LEN-1:0] bsr_pins_i,
    output logic               sr_lsb
);

    logic byp_lsb, id_lsb, uc_lsb, bsr_lsb;

    scan_shift_reg #(.W(1)) u_bypass (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .cap_en(cap_dr && path == PATH_BYPASS),
        .shift_en(shift_dr && path == PATH_BYPASS),
        .cap_val(1'b0), .lsb(byp_lsb)
    );

    scan_shift_reg #(.W(ID_W)) u_idcode (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .cap_en(cap_dr && path == PATH_IDCODE),
        .shift_en(shift_dr && path == PATH_IDCODE),
        .cap_val(IDCODE_VAL), .lsb(id_lsb)
    );

    scan_shift_reg #(.W(ID_W)) u_usercode (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .cap_en(cap_dr && path == PATH_USERCODE),
        .shift_en(shift_dr && path == PATH_USERCODE),
        .cap_val(USERCODE_VAL), .lsb(uc_lsb)
    );

    scan_shift_reg #(.W(BSR_LEN)) u_boundary (
        .tck(tck), .trst_n(trst_n), .tdi(tdi),
        .cap_en(cap_dr && path == PATH_BOUNDARY),
        .shift_en(shift_dr && path == PATH_BOUNDARY),
        .cap_val(bsr_pins_i), .lsb(bsr_lsb)
    );

    always_comb begin
        case (path)
            PATH_IDCODE:   sr_lsb = id_lsb;
            PATH_USERCODE: sr_lsb = uc_lsb;
            PATH_BOUNDARY: sr_lsb = bsr_lsb;
            default:       sr_lsb = byp_lsb;
        endcase
    end

    p_bypass_zero_r6: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && path == PATH_BYPASS) |=> (sr_lsb == 1'b0));

    p_id_lsb_one_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (cap_dr && path == PATH_IDCODE) |=> (sr_lsb == 1'b1));

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
    import scan_port_pkg::*;
#(
    parameter int              IR_W         = 10,
    parameter int              BSR_LEN      = 636,
    parameter logic [ID_W-1:0] IDCODE_VAL   = 32'h020A30DD,
    parameter logic [ID_W-1:0] USERCODE_VAL = 32'hFFFFFFFF,
    parameter logic [IR_W-1:0] OP_IDCODE    = 10'h006,
    parameter logic [IR_W-1:0] OP_USERCODE  = 10'h007,
    parameter logic [IR_W-1:0] OP_SAMPLE    = 10'h005,
    parameter logic [IR_W-1:0] OP_USER0     = 10'h00C,
    parameter logic [IR_W-1:0] OP_USER1     = 10'h00E
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_en,
    output logic [3:0]         tap_state,
    input  logic [BSR_LEN-1:0] bsr_pins_i,
    output logic               usr_tdi,
    input  logic [1:0]         usr_tdo_i,
    output logic [1:0]         usr_sel,
    output logic [1:0]         usr_cap,
    output logic [1:0]         usr_shf,
    output logic [1:0]         usr_upd
);

    tap_state_e      state;
    logic            in_reset, cap_dr, shift_dr, upd_dr, cap_ir, shift_ir, upd_ir;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb, bank_lsb, serial;
    dr_path_e        path;

    scan_fsm u_fsm (
        .tck(tck), .trst_n(trst_n), .tms(tms), .state(state),
        .in_reset(in_reset), .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .shift_ir(shift_ir), .upd_ir(upd_ir)
    );

    scan_ir #(.IR_W(IR_W), .RESET_OP(OP_IDCODE)) u_ir (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .in_reset(in_reset),
        .cap_ir(cap_ir), .shift_ir(shift_ir), .upd_ir(upd_ir),
        .ir_q(ir_q), .sr_lsb(ir_lsb)
    );

    scan_decode #(
        .IR_W(IR_W), .OP_IDCODE(OP_IDCODE), .OP_USERCODE(OP_USERCODE),
        .OP_SAMPLE(OP_SAMPLE), .OP_USER0(OP_USER0), .OP_USER1(OP_USER1)
    ) u_dec (
        .ir_q(ir_q), .path(path)
    );

    scan_dr_bank #(
        .BSR_LEN(BSR_LEN), .IDCODE_VAL(IDCODE_VAL), .USERCODE_VAL(USERCODE_VAL)
    ) u_bank (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .path(path),
        .cap_dr(cap_dr), .shift_dr(shift_dr), .bsr_pins_i(bsr_pins_i),
        .sr_lsb(bank_lsb)
    );

    // Per-chain select and strobes
    generate
        for (genvar k = 0; k < N_USER; k++) begin : g_chain
            assign usr_sel[k] = (path == ((k == 0) ? PATH_USER0 : PATH_USER1));
            assign usr_cap[k] = usr_sel[k] && cap_dr;
            assign usr_shf[k] = usr_sel[k] && shift_dr;
            assign usr_upd[k] = usr_sel[k] && upd_dr;
        end
    endgenerate

    assign usr_tdi   = tdi;
    assign tap_state = state;

    always_comb begin
        serial = 1'b0;
        if (shift_ir)      serial = ir_lsb;
        else if (shift_dr) serial = (|usr_sel) ? |(usr_sel & usr_tdo_i) : bank_lsb;
    end

    // Output stage on the falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo    <= serial;
            tdo_en <= shift_ir || shift_dr;
        end
    end

    p_user_sel_onehot_r9: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0(usr_sel));

    p_strobes_gated_r10: assert property (@(posedge tck) disable iff (!trst_n)
        ((usr_cap | usr_shf | usr_upd) & ~usr_sel) == 2'b00);

    p_tdo_en_shift_r8: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en |-> (shift_ir || shift_dr));

endmodule

// File: tb/scan_port_ctrl_tb.sv
`timescale 1ns/100ps
module scan_port_ctrl_tb;

    localparam int          IR_W = 10;
    localparam int          BSR  = 24;
    localparam logic [31:0] IDV  = 32'h020A30DD;
    localparam logic [31:0] UCV  = 32'hC0DE5A17;
    localparam logic [9:0]  OPID = 10'h006, OPUC = 10'h007, OPSA = 10'h005;
    localparam logic [9:0]  OPU0 = 10'h00C, OPU1 = 10'h00E;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_en, usr_tdi;
    logic [3:0] tap_state;
    logic [BSR-1:0] bsr_pins = 24'hC35A96;
    logic [1:0] usr_tdo_i, usr_sel, usr_cap, usr_shf, usr_upd;

    int n_tests = 0, n_fail = 0;
    int cap_cnt[2], upd_cnt[2];
    logic [7:0] u0 = '0;
    logic [4:0] u1 = '0;
    logic pre_fall, en_seen, en_after;

    always #2 tck = ~tck;

    scan_port_ctrl #(
        .IR_W(IR_W), .BSR_LEN(BSR), .IDCODE_VAL(IDV), .USERCODE_VAL(UCV)
    ) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
        .tdo_en(tdo_en), .tap_state(tap_state), .bsr_pins_i(bsr_pins),
        .usr_tdi(usr_tdi), .usr_tdo_i(usr_tdo_i), .usr_sel(usr_sel),
        .usr_cap(usr_cap), .usr_shf(usr_shf), .usr_upd(usr_upd)
    );

    // Bench model of two user chains: 8 bits capturing 8'hA5, 5 bits capturing 5'h13
    assign usr_tdo_i = {u1[0], u0[0]};
    initial begin cap_cnt = '{0, 0}; upd_cnt = '{0, 0}; end
    always @(posedge tck) begin
        if (usr_cap[0])      u0 <= 8'hA5;
        else if (usr_shf[0]) u0 <= {usr_tdi, u0[7:1]};
        if (usr_cap[1])      u1 <= 5'h13;
        else if (usr_shf[1]) u1 <= {usr_tdi, u1[4:1]};
        for (int k = 0; k < 2; k++) begin
            if (usr_cap[k]) cap_cnt[k] <= cap_cnt[k] + 1;
            if (usr_upd[k]) upd_cnt[k] <= upd_cnt[k] + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    task automatic do_reset();
        trst_n = 1'b0; tms = 1'b1;
        #0.5;
        chk("R2 async reset state", 64'(tap_state), 64'd0);
        step(1'b1, 1'b0);
        trst_n = 1'b1;
    endtask

    function automatic int nxt_model(input int s, input logic m);
        case (s)
            0:  return m ? 0 : 1;
            1:  return m ? 2 : 1;
            2:  return m ? 9 : 3;
            3:  return m ? 5 : 4;
            4:  return m ? 5 : 4;
            5:  return m ? 8 : 6;
            6:  return m ? 7 : 6;
            7:  return m ? 8 : 4;
            8:  return m ? 2 : 1;
            9:  return m ? 0 : 10;
            10: return m ? 12 : 11;
            11: return m ? 12 : 11;
            12: return m ? 15 : 13;
            13: return m ? 14 : 13;
            14: return m ? 15 : 11;
            default: return m ? 2 : 1;
        endcase
    endfunction

    int         p_len[16] = '{0, 1, 2, 3, 4, 4, 5, 6, 5, 3, 4, 5, 5, 6, 7, 6};
    logic [6:0] p_bits[16] = '{7'b0, 7'b0, 7'b10, 7'b010, 7'b0010, 7'b1010, 7'b01010,
                               7'b101010, 7'b11010, 7'b110, 7'b0110, 7'b00110,
                               7'b10110, 7'b010110, 7'b1010110, 7'b110110};

    task automatic go_state(input int s);
        for (int i = 0; i < p_len[s]; i++) step(p_bits[s][i], 1'b0);
    endtask

    task automatic ir_scan(input logic [IR_W-1:0] op, output logic [IR_W-1:0] cap);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < IR_W; i++) begin
            cap[i] = tdo;
            step(i == IR_W - 1, op[i]);
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic dr_scan(input logic [63:0] din, input int n, output logic [63:0] dout);
        dout = '0;
        step(1, 0); step(0, 0);
        tms = 1'b0; tdi = 1'b0;
        @(posedge tck); #1; pre_fall = tdo;
        @(negedge tck); #1; en_seen = tdo_en;
        for (int i = 0; i < n; i++) begin
            dout[i] = tdo;
            step(i == n - 1, din[i]);
        end
        en_after = tdo_en;
        step(1, 0); step(0, 0);
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [IR_W-1:0] capir;
        logic [63:0] dout, din, exp, cv;
        int L, c0, c1, g0, g1;
        string tag;

        @(negedge tck); #1;
        do_reset();
        chk("R2 reset tdo", 64'(tdo), 64'd0);
        chk("R8 reset tdo_en", 64'(tdo_en), 64'd0);
        chk("R9 reset usr_sel", 64'(usr_sel), 64'd0);

        // R1: every state, both TMS values
        for (int s = 0; s < 16; s++) begin
            for (int t = 0; t < 2; t++) begin
                do_reset();
                go_state(s);
                chk("R1 reach state", 64'(tap_state), 64'(s));
                step(t[0], 1'b0);
                chk("R1 transition", 64'(tap_state), 64'(nxt_model(s, t[0])));
            end
        end

        // R2: five TMS ones from every state
        for (int s = 0; s < 16; s++) begin
            do_reset();
            go_state(s);
            for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
            chk("R2 five ones", 64'(tap_state), 64'd0);
        end

        // R4 / R8: data scan right after reset
        do_reset();
        step(0, 0);
        dr_scan(64'd0, 32, dout);
        chk("R4 idcode after reset", dout, 64'(IDV));
        chk("R8 tdo before fall", 64'(pre_fall), 64'd0);
        chk("R8 tdo_en in shift", 64'(en_seen), 64'd1);
        chk("R8 tdo_en after exit", 64'(en_after), 64'd0);

        // R11: instruction survives data scans
        ir_scan(OPUC, capir);
        dr_scan(64'd0, 32, dout);
        chk("R11 usercode first", dout, 64'(UCV));
        dr_scan(64'hFFFF_FFFF, 32, dout);
        chk("R11 usercode second", dout, 64'(UCV));

        // R7: second boundary pattern
        bsr_pins = 24'h0F_F0_3C;
        ir_scan(OPSA, capir);
        dr_scan(64'd0, BSR, dout);
        chk("R7 boundary capture", dout, 64'(24'h0FF03C));
        bsr_pins = 24'hC35A96;

        // R9 / R10: user chain 0 scan with update
        ir_scan(OPU0, capir);
        c0 = upd_cnt[0]; g1 = cap_cnt[1];
        dr_scan(64'h3C, 8, dout);
        chk("R9 chain0 out", dout, 64'hA5);
        chk("R10 chain0 shifted data", 64'(u0), 64'h3C);
        chk("R10 chain0 update once", 64'(upd_cnt[0] - c0), 64'd1);
        chk("R10 chain1 idle", 64'(cap_cnt[1] - g1), 64'd0);

        // R2: reset in the middle of a user-1 shift
        ir_scan(OPU1, capir);
        chk("R9 chain1 select", 64'(usr_sel), 64'd2);
        step(1, 0); step(0, 0); step(0, 0);
        do_reset();
        chk("R2 reset drops select", 64'(usr_sel), 64'd0);
        step(0, 0);
        dr_scan(64'd0, 32, dout);
        chk("R2 idcode after trst", dout, 64'(IDV));

        // Sweep of every opcode
        for (int op = 0; op < 1024; op++) begin
            ir_scan(op[9:0], capir);
            chk("R3 capture pattern", 64'(capir), 64'h001);
            case (op[9:0])
                OPID:    begin L = 32;  cv = 64'(IDV);      tag = "R4 idcode path"; end
                OPUC:    begin L = 32;  cv = 64'(UCV);      tag = "R5 usercode path"; end
                OPSA:    begin L = BSR; cv = 64'(bsr_pins); tag = "R7 boundary path"; end
                OPU0:    begin L = 8;   cv = 64'hA5;        tag = "R9 user0 path"; end
                OPU1:    begin L = 5;   cv = 64'h13;        tag = "R9 user1 path"; end
                default: begin L = 1;   cv = 64'd0;         tag = "R6 bypass path"; end
            endcase
            chk("R9 select per opcode", 64'(usr_sel),
                (op[9:0] == OPU0) ? 64'd1 : (op[9:0] == OPU1) ? 64'd2 : 64'd0);
            din = 64'h0F1E_2D3C_4B5A_6978 ^ 64'(op);
            exp = '0;
            for (int i = 0; i < 40; i++) exp[i] = (i < L) ? cv[i] : din[i - L];
            c0 = cap_cnt[0]; c1 = cap_cnt[1]; g0 = upd_cnt[0]; g1 = upd_cnt[1];
            dr_scan(din, 40, dout);
            chk(tag, dout, exp);
            chk("R10 chain0 capture count", 64'(cap_cnt[0] - c0), (op[9:0] == OPU0) ? 64'd1 : 64'd0);
            chk("R10 chain1 capture count", 64'(cap_cnt[1] - c1), (op[9:0] == OPU1) ? 64'd1 : 64'd0);
            chk("R10 chain0 update count", 64'(upd_cnt[0] - g0), (op[9:0] == OPU0) ? 64'd1 : 64'd0);
            chk("R10 chain1 update count", 64'(upd_cnt[1] - g1), (op[9:0] == OPU1) ? 64'd1 : 64'd0);
            if (op[9:0] == OPU0) chk("R10 chain0 holds tail", 64'(u0), 64'(din[39:32]));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule